// File: doc/BRIEF.md
# Transmit Descriptor Sequencer

This block works through a ring of transmit descriptors in a shared word-wide memory and turns each ready one into a stream of bytes on a valid/ready output. Every descriptor takes four memory words. The status word is at offset 0, the byte count at offset 1 and the buffer word address at offset 2. Each data byte sits in the low eight bits of its own word. After a buffer has been sent, the sequencer writes a new status word back to the descriptor. It then moves to the next descriptor, or goes back to the programmed base when the descriptor carries the wrap flag. The table length is set only by where the wrap flag appears.

Flags in each descriptor control the sequencing. The end-of-frame flag marks the last byte of a frame. The check-sequence flag asks the downstream framer for a frame check sequence. The event flag pulses an event output, and that pulse reaches the interrupt output only when interrupts are enabled. The continuous flag leaves the buffer owned by the sequencer, so the buffer is sent again on every pass round the ring. An error reported by the byte consumer aborts the buffer, and it always hands the descriptor back to software. A descriptor that is not ready makes the sequencer wait and then read the same descriptor again; it never skips ahead.

Top module: `txbd_seq`

## Requirements
- R1: After reset, tx_valid, tx_last, crc_req, tx_event, irq, mem_re and mem_we are low, and no memory access happens while enable is low.
- R2: With enable high, the first descriptor read is at base_addr. Descriptors are 4 words apart: status at +0, byte count at +1, buffer address at +2. Each byte is the low 8 bits of one word, and bytes leave in ascending address order, one per accepted handshake.
- R3: The status word numbers its bits with bit 0 as the most significant. The vector indices are: ready 15, wrap 13, interrupt 12, last 11, check-sequence 10, continuous 9, error 1. Every other bit (mask 16'h41FD) is written back as zero.
- R4: When a buffer completes with the continuous bit clear, the written status has ready = 0 and error = 0, and the wrap, interrupt, last, check-sequence and continuous bits are kept.
- R5: When a buffer completes with the continuous bit set, ready is written back as 1, and the buffer is sent again the next time that descriptor is reached.
- R6: After a descriptor with the wrap bit set, the next status read is at base_addr, and no descriptor beyond it is read.
- R7: A descriptor read with ready = 0 is not sent. Its count is not fetched, and the same status word is read again after POLL_GAP idle cycles.
- R8: tx_last is high exactly on the final byte of a buffer whose last bit is set. Buffers with last = 0 produce no tx_last.
- R9: crc_req pulses for one cycle, in the cycle after the final byte of a buffer with both last and check-sequence set is accepted, and at no other time.
- R10: tx_event pulses once per closed buffer whose interrupt bit is set, and once per aborted buffer. irq pulses in the same cycle only when irq_en was high.
- R11: err_in high while a byte is offered aborts the buffer. tx_valid drops, no more bytes of that buffer are sent, no crc_req is raised, and the status is written with ready = 0 and error = 1, even when the continuous bit is set.
- R12: While tx_valid is high and tx_ready and err_in are low, tx_data and tx_last hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the descriptor ring |
| base_addr | input | AW | Word address of the first descriptor |
| irq_en | input | 1 | Lets the event pulse reach irq |
| mem_addr | output | AW | Shared memory word address |
| mem_re | output | 1 | Read strobe; data returns one cycle later |
| mem_we | output | 1 | Write strobe for status writeback |
| mem_wdata | output | 16 | Status word being written |
| mem_rdata | input | 16 | Read data, one cycle after mem_re |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Byte on tx_data is valid |
| tx_ready | input | 1 | Consumer accepts the byte |
| tx_last | output | 1 | Byte ends the frame |
| crc_req | output | 1 | Append the frame check sequence now |
| err_in | input | 1 | Consumer error (for example an underrun) |
| tx_event | output | 1 | Buffer-serviced event pulse |
| irq | output | 1 | Interrupt pulse, gated by irq_en |

## Verification
The assertions assume three things about the inputs. The memory answers every read with the addressed word one cycle later. Every ready descriptor holds a nonzero byte count. err_in only counts while a byte is being offered. The bench's memory model has exactly one cycle of latency, and every descriptor it loads has a count between one and three. It raises err_in for a single cycle, and only while a byte is held on a stalled output. Every input changes half a cycle away from the active edge, so each one is stable when the design samples it.

// File: rtl/txbd_pkg.sv
package txbd_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_ST, S_CNT, S_PTR, S_PTRW, S_RD, S_LD, S_SEND, S_WB, S_POLL
  } seq_state_t;

  // vector indices of the status word fields
  localparam int B_RDY  = 15;
  localparam int B_WRAP = 13;
  localparam int B_INT  = 12;
  localparam int B_LAST = 11;
  localparam int B_TC   = 10;
  localparam int B_CONT = 9;
  localparam int B_ERR  = 1;

  localparam logic [15:0] FLAG_KEEP = 16'h3E00;
  localparam int DESC_STRIDE = 4;
endpackage

// File: rtl/txbd_status_upd.sv
module txbd_status_upd
  import txbd_pkg::*;
(
  input  logic [15:0] st_in,
  input  logic        err,
  output logic [15:0] wb_word,
  output logic        fire_evt
);
  always_comb begin
    wb_word         = st_in & FLAG_KEEP;
    wb_word[B_RDY]  = st_in[B_RDY] & st_in[B_CONT] & ~err;
    wb_word[B_ERR]  = err;
    fire_evt        = st_in[B_INT] | err;
  end
endmodule

// File: rtl/txbd_poll_timer.sv
module txbd_poll_timer #(
  parameter int GAP = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done
);
  localparam int TW = $clog2(GAP + 1);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (start)          cnt <= TW'(GAP);
    else if (cnt != '0)      cnt <= cnt - TW'(1);
  end

  assign done = (cnt == TW'(1));
endmodule

// File: rtl/txbd_byte_stage.sv
module txbd_byte_stage #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [BW-1:0] ld_data,
  input  logic          ld_last,
  input  logic          abort,
  input  logic          ready,
  output logic [BW-1:0] data,
  output logic          valid,
  output logic          last
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data  <= '0;
      valid <= 1'b0;
      last  <= 1'b0;
    end else if (load) begin
      data  <= ld_data;
      valid <= 1'b1;
      last  <= ld_last;
    end else if (valid && (ready || abort)) begin
      valid <= 1'b0;
      last  <= 1'b0;
    end
  end
endmodule

// File: rtl/txbd_seq.sv
module txbd_seq
  import txbd_pkg::*;
#(
  parameter int AW       = 8,
  parameter int CW       = 16,
  parameter int POLL_GAP = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic [AW-1:0] base_addr,
  input  logic          irq_en,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  output logic          mem_we,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic          tx_last,
  output logic          crc_req,
  input  logic          err_in,
  output logic          tx_event,
  output logic          irq
);
  seq_state_t    state;
  logic [AW-1:0] cur;
  logic [AW-1:0] ptr_q;
  logic [15:0]   st_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] idx;
  logic          err_q;
  logic          last_idx;
  logic          poll_start;
  logic          poll_done;
  logic          fire_evt;
  logic          abort;

  assign last_idx   = (idx == cnt_q - CW'(1));
  assign poll_start = (state == S_CNT) && !mem_rdata[B_RDY];
  assign abort      = (state == S_SEND) && err_in;

  txbd_status_upd u_upd (
    .st_in    (st_q),
    .err      (err_q),
    .wb_word  (mem_wdata),
    .fire_evt (fire_evt)
  );

  txbd_poll_timer #(.GAP(POLL_GAP)) u_poll (
    .clk   (clk),
    .rst   (rst),
    .start (poll_start),
    .done  (poll_done)
  );

  txbd_byte_stage #(.BW(8)) u_out (
    .clk     (clk),
    .rst     (rst),
    .load    (state == S_LD),
    .ld_data (mem_rdata[7:0]),
    .ld_last (last_idx && st_q[B_LAST]),
    .abort   (abort),
    .ready   (tx_ready),
    .data    (tx_data),
    .valid   (tx_valid),
    .last    (tx_last)
  );

  always_comb begin
    mem_re   = 1'b0;
    mem_we   = 1'b0;
    mem_addr = cur;
    case (state)
      S_ST:  mem_re = 1'b1;
      S_CNT: begin
        mem_re   = mem_rdata[B_RDY];
        mem_addr = cur + AW'(1);
      end
      S_PTR: begin
        mem_re   = 1'b1;
        mem_addr = cur + AW'(2);
      end
      S_RD: begin
        mem_re   = 1'b1;
        mem_addr = ptr_q + AW'(idx);
      end
      S_WB:  mem_we = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      cur      <= '0;
      ptr_q    <= '0;
      st_q     <= '0;
      cnt_q    <= '0;
      idx      <= '0;
      err_q    <= 1'b0;
      crc_req  <= 1'b0;
      tx_event <= 1'b0;
      irq      <= 1'b0;
    end else begin
      crc_req  <= 1'b0;
      tx_event <= 1'b0;
      irq      <= 1'b0;
      case (state)
        S_IDLE: if (enable) begin
          cur   <= base_addr;
          state <= S_ST;
        end
        S_ST:  state <= S_CNT;
        S_CNT: begin
          st_q  <= mem_rdata;
          state <= mem_rdata[B_RDY] ? S_PTR : S_POLL;
        end
        S_PTR: begin
          cnt_q <= mem_rdata[CW-1:0];
          state <= S_PTRW;
        end
        S_PTRW: begin
          ptr_q <= mem_rdata[AW-1:0];
          idx   <= '0;
          err_q <= 1'b0;
          state <= S_RD;
        end
        S_RD:  state <= S_LD;
        S_LD:  state <= S_SEND;
        S_SEND: begin
          if (err_in) begin
            err_q <= 1'b1;
            state <= S_WB;
          end else if (tx_ready) begin
            if (last_idx) begin
              crc_req <= st_q[B_LAST] & st_q[B_TC];
              state   <= S_WB;
            end else begin
              idx   <= idx + CW'(1);
              state <= S_RD;
            end
          end
        end
        S_WB: begin
          tx_event <= fire_evt;
          irq      <= fire_evt & irq_en;
          cur      <= st_q[B_WRAP] ? base_addr : cur + AW'(DESC_STRIDE);
          state    <= enable ? S_ST : S_IDLE;
        end
        S_POLL: begin
          if (!enable)        state <= S_IDLE;
          else if (poll_done) state <= S_ST;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txbd_seq_chk.sv
module txbd_seq_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          irq_en,
  input logic [AW-1:0] mem_addr,
  input logic          mem_re,
  input logic          mem_we,
  input logic [15:0]   mem_wdata,
  input logic [7:0]    tx_data,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic          tx_last,
  input logic          crc_req,
  input logic          err_in,
  input logic          tx_event,
  input logic          irq
);
  p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ((mem_wdata & 16'h41FD) == 16'h0000));

  p_err_clears_ready_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_wdata[1]) |-> !mem_wdata[15]);

  p_err_drops_valid_r11: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && err_in) |=> !tx_valid);

  p_hold_byte_r12: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !err_in) |=>
      (tx_valid && $stable(tx_data) && $stable(tx_last)));

  p_crc_after_last_r9: assert property (@(posedge clk) disable iff (rst)
    crc_req |-> $past(tx_valid && tx_ready && tx_last && !err_in));

  p_irq_gated_r10: assert property (@(posedge clk) disable iff (rst)
    irq |-> (tx_event && $past(irq_en)));

  p_single_access_r2: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));

  p_addr_known_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_re || mem_we) |-> !$isunknown(mem_addr));
endmodule

bind txbd_seq txbd_seq_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq_en    (irq_en),
  .mem_addr  (mem_addr),
  .mem_re    (mem_re),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .tx_data   (tx_data),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_last   (tx_last),
  .crc_req   (crc_req),
  .err_in    (err_in),
  .tx_event  (tx_event),
  .irq       (irq)
);

// File: tb/txbd_seq_tb.sv
`timescale 1ns/1ps
module txbd_seq_tb;
  localparam int AW = 8;
  localparam int POLL_GAP = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enable = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic          irq_en = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_re, mem_we;
  logic [15:0]   mem_wdata;
  logic [15:0]   mem_rdata;
  logic [7:0]    tx_data;
  logic          tx_valid, tx_last, crc_req, tx_event, irq;
  logic          tx_ready;
  logic          err_in = 1'b0;
  int            rdy_mode = 0;
  int            cyc = 0;

  logic [15:0] mem [0:255];
  logic [7:0]  got [0:63];
  int rdc [0:255];
  int nbytes, nlast, ncrc, nev, nirq;
  int nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  txbd_seq #(.AW(AW), .CW(16), .POLL_GAP(POLL_GAP)) u_dut (
    .clk(clk), .rst(rst), .enable(enable), .base_addr(base_addr),
    .irq_en(irq_en), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last),
    .crc_req(crc_req), .err_in(err_in), .tx_event(tx_event), .irq(irq)
  );

  assign tx_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? ((cyc % 3) != 0) : 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (tx_valid && tx_ready && !err_in) begin
        if (nbytes < 64) got[nbytes] = tx_data;
        if (tx_last) nlast++;
        nbytes++;
      end
      if (crc_req)  ncrc++;
      if (tx_event) nev++;
      if (irq)      nirq++;
      if (mem_re)   rdc[mem_addr]++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic restart();
    rst = 1'b1; enable = 1'b0; err_in = 1'b0; rdy_mode = 0;
    for (int i = 0; i < 256; i++) begin mem[i] = 16'h0; rdc[i] = 0; end
    nbytes = 0; nlast = 0; ncrc = 0; nev = 0; nirq = 0;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic wait_bytes(input int n, input int lim, input string req);
    int k = 0;
    while (nbytes < n && k < lim) begin @(negedge clk); #1; k++; end
    check(nbytes >= n, req, nbytes, n);
  endtask

  task automatic t_reset();
    int seen = 0;
    restart();
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (tx_valid || tx_last || crc_req || tx_event || irq || mem_re || mem_we) seen++;
    end
    check(seen == 0, "R1 idle outputs", seen, 0);
  endtask

  task automatic t_basic();
    restart();
    base_addr = 8'h10; irq_en = 1'b1; rdy_mode = 1;
    mem[8'h10] = 16'hC1FD; mem[8'h11] = 3; mem[8'h12] = 16'h0080;
    mem[8'h14] = 16'hBC00; mem[8'h15] = 2; mem[8'h16] = 16'h0090;
    mem[8'h18] = 16'h8000; mem[8'h19] = 1; mem[8'h1A] = 16'h00A0;
    mem[8'h80] = 16'h00A0; mem[8'h81] = 16'h00A1; mem[8'h82] = 16'h00A2;
    mem[8'h90] = 16'h00B0; mem[8'h91] = 16'h00B1;
    #1 enable = 1'b1;
    wait_bytes(5, 400, "R2 byte count");
    repeat (40) @(negedge clk);
    #1 enable = 1'b0;
    repeat (20) @(negedge clk);
    check(nbytes == 5, "R2 total bytes", nbytes, 5);
    check(got[0] == 8'hA0 && got[1] == 8'hA1 && got[2] == 8'hA2, "R2 first buffer",
          {got[0], got[1], got[2]}, 24'hA0A1A2);
    check(got[3] == 8'hB0 && got[4] == 8'hB1, "R2 second buffer", {got[3], got[4]}, 16'hB0B1);
    check(mem[8'h10] == 16'h0000, "R3 reserved bits cleared", mem[8'h10], 16'h0000);
    check(mem[8'h14] == 16'h3C00, "R4 status written", mem[8'h14], 16'h3C00);
    check(nlast == 1, "R8 one frame end", nlast, 1);
    check(ncrc == 1, "R9 one crc request", ncrc, 1);
    check(nev == 1 && nirq == 1, "R10 event and irq", nev * 16 + nirq, 16'h11);
    check(rdc[8'h18] == 0, "R6 no read past wrap", rdc[8'h18], 0);
    check(rdc[8'h10] >= 2, "R6 base reread", rdc[8'h10], 2);
    check(mem[8'h18] == 16'h8000, "R6 untouched descriptor", mem[8'h18], 16'h8000);
  endtask

  task automatic t_continuous();
    restart();
    base_addr = 8'h20; irq_en = 1'b0;
    mem[8'h20] = 16'hAA00; mem[8'h21] = 2; mem[8'h22] = 16'h0040;
    mem[8'h40] = 16'h00C0; mem[8'h41] = 16'h00C1;
    #1 enable = 1'b1;
    wait_bytes(6, 400, "R5 repeat bytes");
    #1 enable = 1'b0;
    repeat (20) @(negedge clk);
    check(nbytes == 6, "R5 pass count", nbytes, 6);
    check(got[0] == 8'hC0 && got[1] == 8'hC1 && got[4] == 8'hC0 && got[5] == 8'hC1,
          "R5 resent data", {got[4], got[5]}, 16'hC0C1);
    check(mem[8'h20] == 16'hAA00, "R5 ready kept", mem[8'h20], 16'hAA00);
    check(nlast == 3, "R8 last per pass", nlast, 3);
    check(ncrc == 0, "R9 no crc without flag", ncrc, 0);
    check(nev == 0 && nirq == 0, "R10 no event without flag", nev + nirq, 0);
  endtask

  task automatic t_poll();
    int r;
    restart();
    base_addr = 8'h30; irq_en = 1'b0;
    mem[8'h30] = 16'h0000; mem[8'h31] = 1; mem[8'h32] = 16'h0050;
    mem[8'h34] = 16'h8800; mem[8'h50] = 16'h00D0;
    #1 enable = 1'b1;
    repeat (40) @(negedge clk);
    r = rdc[8'h30];
    check(nbytes == 0, "R7 nothing sent", nbytes, 0);
    check(rdc[8'h31] == 0 && rdc[8'h34] == 0, "R7 no skip", rdc[8'h31] + rdc[8'h34], 0);
    check(r >= 2 && r <= 6, "R7 poll rate", r, 4);
    #1 mem[8'h30] = 16'hA800;
    wait_bytes(1, 200, "R7 picked up");
    #1 enable = 1'b0;
    repeat (20) @(negedge clk);
    check(got[0] == 8'hD0, "R7 byte", got[0], 8'hD0);
    check(mem[8'h30] == 16'h2800, "R4 closed status", mem[8'h30], 16'h2800);
  endtask

  task automatic t_error();
    int k = 0;
    restart();
    base_addr = 8'h40; irq_en = 1'b0; rdy_mode = 2;
    mem[8'h40] = 16'hBE00; mem[8'h41] = 3; mem[8'h42] = 16'h0060;
    mem[8'h60] = 16'h00E0; mem[8'h61] = 16'h00E1; mem[8'h62] = 16'h00E2;
    #1 enable = 1'b1;
    while (!tx_valid && k < 200) begin @(negedge clk); #1; k++; end
    check(tx_valid == 1'b1, "R12 byte offered", tx_valid, 1);
    repeat (3) @(negedge clk);
    #1;
    check(tx_valid && tx_data == 8'hE0, "R12 held byte", tx_data, 8'hE0);
    err_in = 1'b1; enable = 1'b0;
    @(negedge clk);
    #1 err_in = 1'b0;
    check(!tx_valid, "R11 valid dropped", tx_valid, 0);
    rdy_mode = 0;
    repeat (20) @(negedge clk);
    check(nbytes == 0, "R11 no bytes", nbytes, 0);
    check(mem[8'h40] == 16'h3E02, "R11 error status", mem[8'h40], 16'h3E02);
    check(ncrc == 0, "R11 no crc", ncrc, 0);
    check(nev == 1 && nirq == 0, "R10 gated irq", nev * 16 + nirq, 16'h10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_continuous();
    t_poll();
    t_error();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule